// File: doc/BRIEF.md
# Write-Through Store Queue

This block sits between a write-through data cache and main memory. Each processor store is written into the cache line and also pushed into a short first-in first-out queue that holds an address and a data word per entry. A memory-side engine hands the oldest entry to memory over a valid/ready handshake. The processor only has to wait when every slot of the queue is taken. Memory writes never hold up a store that finds room.

Before a read miss goes to memory, the cache controller presents the miss address on a combinational lookup port. If a store to that address is still in the queue, the port returns its data, so memory is never read while a newer value is pending. When more than one queued store targets the address, the most recently queued one is returned. The full and empty flags are exported. The empty flag lets the controller hold a later read until every earlier write has reached memory.

Top module: `wtq_store_buffer`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `mem_valid` is 0, `st_stall` is 0 and `rd_hit` is 0.
- R2: A store accepted into an empty queue appears on `mem_valid`, `mem_addr` and `mem_data` in the cycle after the accepting clock edge.
- R3: Entries leave on the memory port in the same order the stores were accepted. Each accepted store leaves exactly once.
- R4: With DEPTH entries pending, `full` is 1 and `st_stall` follows `st_valid`. A store offered while full is not taken: it never reaches memory and never matches a lookup.
- R5: An entry stays at the head, with `mem_addr` and `mem_data` unchanged, until a cycle in which `mem_ready` is 1 while `mem_valid` is 1. Only that cycle frees the entry.
- R6: `rd_hit` is 1 and `rd_data` equals the queued word when a pending entry has the address `rd_addr`. Otherwise `rd_hit` is 0.
- R7: When several pending entries match `rd_addr`, `rd_data` is the data of the one accepted last.
- R8: A store that is accepted in the same cycle as a memory handshake leaves the occupancy unchanged.
- R9: `empty` is 1 exactly when no entry is pending. `full` drops once one entry drains from a full queue.
- R10: An entry that memory has accepted no longer matches a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Processor store request |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data word |
| st_stall | output | 1 | Store not taken this cycle (queue full) |
| mem_valid | output | 1 | Head entry offered to memory |
| mem_addr | output | AW | Head entry address |
| mem_data | output | DW | Head entry data |
| mem_ready | input | 1 | Memory accepts the head entry |
| rd_addr | input | AW | Read-miss lookup address |
| rd_hit | output | 1 | A pending store matches `rd_addr` |
| rd_data | output | DW | Data of the youngest matching store |
| full | output | 1 | All entries occupied |
| empty | output | 1 | No entry pending |

## Verification
The queue is filled to capacity while memory is held off. This shows that backpressure holds the head steady and that a store offered while full is dropped and does not overwrite anything. Lookups are made with a unique address, a missing address and an address written twice, which separates a plain hit, a miss and youngest-entry forwarding. A cycle with both a store and a drain, followed by one more store, shows whether the occupancy count stayed put: a queue that counted wrong would raise `full` at the wrong moment. A scoreboard compares every drained entry with the expected order.

// File: rtl/wtq_pkg.sv
package wtq_pkg;

   // Physical slot that is k places after base in a ring of depth slots.
   function automatic int unsigned slot_of(input int unsigned base,
                                           input int unsigned k,
                                           input int unsigned depth);
      return (base + k) % depth;
   endfunction

endpackage

// File: rtl/wtq_ring.sv
module wtq_ring #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int DEPTH = 4,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = PW + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  logic [AW-1:0]            push_addr,
   input  logic [DW-1:0]            push_data,
   input  logic                     pop,
   output logic [CW-1:0]            count,
   output logic [PW-1:0]            rd_ptr,
   output logic [DEPTH-1:0][AW-1:0] slot_addr,
   output logic [DEPTH-1:0][DW-1:0] slot_data
);

   logic [PW-1:0] wr_ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + PW'(1);
         if (pop)  rd_ptr <= rd_ptr + PW'(1);
         case ({push, pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         slot_addr[wr_ptr] <= push_addr;
         slot_data[wr_ptr] <= push_data;
      end
   end

endmodule

// File: rtl/wtq_match.sv
module wtq_match #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int DEPTH = 4,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = PW + 1
) (
   input  logic [DEPTH-1:0][AW-1:0] slot_addr,
   input  logic [DEPTH-1:0][DW-1:0] slot_data,
   input  logic [PW-1:0]            rd_ptr,
   input  logic [CW-1:0]            count,
   input  logic [AW-1:0]            look_addr,
   output logic                     hit,
   output logic [DW-1:0]            data
);

   logic [DEPTH-1:0] eq;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign eq[g] = (slot_addr[g] == look_addr);
   end

   // Walk from oldest to youngest; a later match overrides an earlier one.
   always_comb begin
      hit  = 1'b0;
      data = '0;
      for (int k = 0; k < DEPTH; k++) begin
         logic [PW-1:0] idx;
         idx = PW'(wtq_pkg::slot_of(int'(rd_ptr), k, DEPTH));
         if ((CW'(k) < count) && eq[idx]) begin
            hit  = 1'b1;
            data = slot_data[idx];
         end
      end
   end

endmodule

// File: rtl/wtq_store_buffer.sv
module wtq_store_buffer #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int DEPTH = 4,
   localparam int PW   = $clog2(DEPTH),
   localparam int CW   = PW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          st_valid,
   input  logic [AW-1:0] st_addr,
   input  logic [DW-1:0] st_data,
   output logic          st_stall,
   output logic          mem_valid,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_data,
   input  logic          mem_ready,
   input  logic [AW-1:0] rd_addr,
   output logic          rd_hit,
   output logic [DW-1:0] rd_data,
   output logic          full,
   output logic          empty
);

   initial begin : param_check
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two, at least 2");
      assert (AW > 0 && DW > 0)
         else $error("AW and DW must be positive");
   end

   logic [CW-1:0]            count;
   logic [PW-1:0]            rd_ptr;
   logic [DEPTH-1:0][AW-1:0] slot_addr;
   logic [DEPTH-1:0][DW-1:0] slot_data;
   logic                     push, pop;

   assign full      = (count == CW'(DEPTH));
   assign empty     = (count == '0);
   assign st_stall  = st_valid & full;
   assign push      = st_valid & ~full;
   assign mem_valid = ~empty;
   assign pop       = mem_valid & mem_ready;
   assign mem_addr  = slot_addr[rd_ptr];
   assign mem_data  = slot_data[rd_ptr];

   wtq_ring #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_addr (st_addr),
      .push_data (st_data),
      .pop       (pop),
      .count     (count),
      .rd_ptr    (rd_ptr),
      .slot_addr (slot_addr),
      .slot_data (slot_data)
   );

   wtq_match #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_match (
      .slot_addr (slot_addr),
      .slot_data (slot_data),
      .rd_ptr    (rd_ptr),
      .count     (count),
      .look_addr (rd_addr),
      .hit       (rd_hit),
      .data      (rd_data)
   );

endmodule

// File: rtl/wtq_checker.sv
module wtq_checker #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int DEPTH = 4,
   localparam int CW   = $clog2(DEPTH) + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          st_valid,
   input logic          st_stall,
   input logic          mem_valid,
   input logic          mem_ready,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_data,
   input logic          rd_hit,
   input logic          full,
   input logic          empty
);

   logic          acc, drn;
   logic [CW-1:0] shadow;

   assign acc = st_valid & ~st_stall;
   assign drn = mem_valid & mem_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shadow <= '0;
      else        shadow <= shadow + CW'(acc) - CW'(drn);
   end

   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      shadow <= CW'(DEPTH));

   p_full_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      full == (shadow == CW'(DEPTH)));

   p_empty_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      empty == (shadow == '0));

   p_head_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

   p_same_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && drn) |=> (full == $past(full) && empty == $past(empty)));

   p_no_hit_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !rd_hit);

endmodule

bind wtq_store_buffer wtq_checker #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .st_valid  (st_valid),
   .st_stall  (st_stall),
   .mem_valid (mem_valid),
   .mem_ready (mem_ready),
   .mem_addr  (mem_addr),
   .mem_data  (mem_data),
   .rd_hit    (rd_hit),
   .full      (full),
   .empty     (empty)
);

// File: tb/tb_wtq_store_buffer.sv
module tb_wtq_store_buffer;

   localparam int AW = 32;
   localparam int DW = 32;
   localparam int DEPTH = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          st_valid = 1'b0;
   logic [AW-1:0] st_addr = '0;
   logic [DW-1:0] st_data = '0;
   logic          st_stall;
   logic          mem_valid;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_data;
   logic          mem_ready = 1'b0;
   logic [AW-1:0] rd_addr = '0;
   logic          rd_hit;
   logic [DW-1:0] rd_data;
   logic          full, empty;

   int n_chk = 0;
   int n_fail = 0;
   logic [AW+DW-1:0] sb[$];

   always #2 clk = ~clk;

   wtq_store_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut (.*);

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Monitor: a handshake seen at the negedge completes at the next posedge.
   always @(negedge clk) begin
      if (rst_n && mem_valid && mem_ready) begin
         if (sb.size() == 0) chk(1'b0, "R3 unexpected drain", mem_addr, 0);
         else begin
            logic [AW+DW-1:0] e;
            e = sb.pop_front();
            chk({mem_addr, mem_data} == e, "R3 drain order", {mem_addr, mem_data}, e);
         end
      end
   end

   // Drive one store; hold it until taken, then record it.
   task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(posedge clk); #1;
      st_valid = 1'b1; st_addr = a; st_data = d;
      @(negedge clk);
      while (st_stall) begin
         @(posedge clk); #1;
         @(negedge clk);
      end
      sb.push_back({a, d});
      @(posedge clk); #1;
      st_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
      #1;
   endtask

   task automatic look(input logic [AW-1:0] a, input bit exp_hit,
                       input logic [DW-1:0] exp_d, input string req);
      rd_addr = a;
      @(negedge clk);
      chk(rd_hit == exp_hit, req, rd_hit, exp_hit);
      if (exp_hit) chk(rd_data == exp_d, req, rd_data, exp_d);
   endtask

   task automatic drain_all;
      @(posedge clk); #1;
      mem_ready = 1'b1;
      for (int i = 0; i < 50 && !empty; i++) begin
         @(posedge clk); #1;
      end
      mem_ready = 1'b0;
   endtask

   initial begin
      #800000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      chk(empty == 1'b1, "R1 empty", empty, 1);
      chk(full == 1'b0, "R1 full", full, 0);
      chk(mem_valid == 1'b0, "R1 mem_valid", mem_valid, 0);
      chk(st_stall == 1'b0 && rd_hit == 1'b0, "R1 stall/hit", {st_stall, rd_hit}, 0);

      // R2: first store shows up at the head the next cycle
      do_store(32'h100, 32'h11);
      @(negedge clk);
      chk(mem_valid == 1'b1, "R2 mem_valid", mem_valid, 1);
      chk(mem_addr == 32'h100 && mem_data == 32'h11, "R2 head", mem_data, 32'h11);
      chk(empty == 1'b0, "R9 not empty", empty, 0);

      look(32'h100, 1'b1, 32'h11, "R6 hit");
      look(32'h200, 1'b0, '0, "R6 miss");

      do_store(32'h104, 32'h22);
      do_store(32'h100, 32'h33);
      do_store(32'h108, 32'h44);
      @(negedge clk);
      chk(full == 1'b1, "R4 full", full, 1);
      look(32'h100, 1'b1, 32'h33, "R7 youngest");

      // R5: head holds under backpressure
      idle(3);
      @(negedge clk);
      chk(mem_addr == 32'h100 && mem_data == 32'h11, "R5 hold", mem_data, 32'h11);

      // R4: store offered while full is dropped
      @(posedge clk); #1;
      st_valid = 1'b1; st_addr = 32'h1FC; st_data = 32'h99;
      @(negedge clk);
      chk(st_stall == 1'b1, "R4 stall", st_stall, 1);
      idle(1);
      @(negedge clk);
      chk(st_stall == 1'b1, "R4 stall held", st_stall, 1);
      @(posedge clk); #1;
      st_valid = 1'b0;
      look(32'h1FC, 1'b0, '0, "R4 dropped store not queued");

      // Single handshake from full
      @(posedge clk); #1;
      mem_ready = 1'b1;
      @(posedge clk); #1;
      mem_ready = 1'b0;
      @(negedge clk);
      chk(full == 1'b0, "R9 full clears", full, 0);
      chk(mem_addr == 32'h104 && mem_data == 32'h22, "R5 next head", mem_data, 32'h22);

      drain_all();
      @(negedge clk);
      chk(empty == 1'b1, "R9 empty after drain", empty, 1);
      look(32'h104, 1'b0, '0, "R10 drained no match");
      look(32'h100, 1'b0, '0, "R10 drained no match");
      chk(sb.size() == 0, "R3 all drained", sb.size(), 0);

      // R8: simultaneous store and drain keep occupancy
      do_store(32'h200, 32'hA0);
      do_store(32'h204, 32'hA1);
      do_store(32'h208, 32'hA2);
      @(posedge clk); #1;
      st_valid = 1'b1; st_addr = 32'h20C; st_data = 32'hA3; mem_ready = 1'b1;
      @(negedge clk);
      sb.push_back({32'h20C, 32'hA3});
      @(posedge clk); #1;
      st_valid = 1'b0; mem_ready = 1'b0;
      @(negedge clk);
      chk(full == 1'b0, "R8 count kept", full, 0);
      chk(mem_addr == 32'h204, "R8 head advanced", mem_addr, 32'h204);
      do_store(32'h210, 32'hA4);
      @(negedge clk);
      chk(full == 1'b1, "R8 full after one more", full, 1);
      look(32'h200, 1'b0, '0, "R10 popped entry gone");
      look(32'h20C, 1'b1, 32'hA3, "R6 hit mid queue");

      drain_all();
      @(negedge clk);
      chk(empty == 1'b1 && mem_valid == 1'b0, "R9 empty end", empty, 1);
      chk(sb.size() == 0, "R3 all drained end", sb.size(), 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule